// File: doc/BRIEF.md
# DDR Power-Down Sequencer

This block owns the clock-enable pin of a DDR SDRAM and steps the memory into and out of its low-power state. A power-down request from the memory controller is accepted only when no read or write burst is running. A burst counts as running from its issue until its postamble has finished. A request that arrives during a burst is held and served once the burst is complete. When entry happens, the block records whether every bank was idle (precharge power-down) or a row was open (active power-down).

While it is powered down, the block keeps clock-enable low until an exit request arrives or a dwell limit expires. The dwell limit forces an exit so that refresh is not starved. The block forces NOP on the command bus in the cycle where clock-enable falls and in the cycle where it rises. A ready output tells the command scheduler when a real command may be issued again.

The state machine has four states. `S_UP` is normal operation. `S_ENTER` is the NOP cycle in which clock-enable goes low. `S_DOWN` is the powered-down dwell. `S_EXIT` is the NOP cycle in which clock-enable goes high. The transitions are:
- enter-go (`S_UP`→`S_ENTER`, when a request is present and no burst is running);
- settle (`S_ENTER`→`S_DOWN`, unconditional);
- wake (`S_DOWN`→`S_EXIT`, on an exit request or dwell expiry);
- resume (`S_EXIT`→`S_UP`, unconditional).

Top module: `ddr_pdn_ctrl`

## Requirements
- R1: After reset, cke is 1, cmd_ready is 1, cmd_nop is 0 and pd_mode is 0 (precharge).
- R2: In normal operation, if pd_req is high or a request is held, and no burst is running, then after the next clock edge cke is 0, cmd_nop is 1 and cmd_ready is 0 (the entry cycle).
- R3: A burst is running while burst_busy is high, and it stays running until a cycle with postamble_done high (burst_busy low) has been registered. A request seen during a burst is held, and entry takes place at the edge that ends the cycle after the postamble_done cycle.
- R4: pd_mode is loaded at the entry edge from banks_idle: 0 when all banks are idle, 1 when a row is open. It holds this value until the next entry.
- R5: In every power-down cycle after the entry cycle, cke is 0, cmd_nop is 0 and cmd_ready is 0. A pd_req that arrives during power-down is discarded and does not cause a later entry.
- R6: An exit_req that is high in a power-down cycle gives, after the next edge, one exit cycle with cke 1, cmd_nop 1 and cmd_ready 0. After the following edge, cmd_ready is 1.
- R7: When MAX_PD_CYCLES power-down cycles have elapsed after the entry cycle, the block exits on its own, as in R6.
- R8: exit_req has no effect outside the power-down dwell state, and this includes the entry cycle.
- R9: cmd_ready is never 1 while cke is 0, and cke changes only in a cycle where cmd_nop is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pd_req | input | 1 | Request to enter power-down |
| exit_req | input | 1 | Request to leave power-down |
| burst_busy | input | 1 | A read or write burst is in flight |
| postamble_done | input | 1 | The postamble of the last burst has finished |
| banks_idle | input | 1 | All banks are precharged |
| cke | output | 1 | Clock enable to the memory |
| cmd_nop | output | 1 | Forces NOP onto the command bus |
| cmd_ready | output | 1 | A valid command may be issued |
| pd_mode | output | 1 | 0 = precharge power-down, 1 = active power-down |

## Verification
On every cycle the assertions check the following:
- each clock-enable edge is paired with a forced NOP;
- readiness is never claimed while clock-enable is low;
- a running burst keeps the block out of the entry cycle;
- the dwell timer expiry leads to a wake;
- the mode bit stays stable through the dwell.

Only the bench scenarios can show the sequences themselves:
- the exact cycle on which a held request is served after the postamble;
- the one-cycle gap before readiness returns;
- the classification of each entry by bank state;
- the full length of a forced dwell;
- that stray requests in the wrong state leave no trace.

// File: rtl/pdn_pkg.sv
package pdn_pkg;
    typedef enum logic [1:0] {
        S_UP    = 2'd0,
        S_ENTER = 2'd1,
        S_DOWN  = 2'd2,
        S_EXIT  = 2'd3
    } pdn_state_e;

    typedef enum logic {
        MODE_PRECHARGE = 1'b0,
        MODE_ACTIVE    = 1'b1
    } pdn_mode_e;
endpackage

// File: rtl/pdn_burst_guard.sv
module pdn_burst_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic burst_busy,
    input  logic postamble_done,
    output logic blocked
);
    // Tail flag: the burst has ended but its postamble has not yet finished.
    logic tail_q;

    always_ff @(posedge clk) begin
        if (!rst_n)              tail_q <= 1'b0;
        else if (burst_busy)     tail_q <= 1'b1;
        else if (postamble_done) tail_q <= 1'b0;
    end

    assign blocked = burst_busy | tail_q;

    // The cycle after a busy burst stays blocked until the postamble is seen.
    p_tail_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        burst_busy |=> blocked);
endmodule

// File: rtl/pdn_dwell_timer.sv
module pdn_dwell_timer #(
    parameter int MAX_PD_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_down,
    output logic expire
);
    localparam int CW = $clog2(MAX_PD_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(MAX_PD_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !in_down) cnt_q <= '0;
        else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
    end

    assign expire = in_down && (cnt_q == LAST);

    // The dwell ends at the edge after expiry.
    p_expire_leaves_r7: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !in_down);
endmodule

// File: rtl/pdn_fsm.sv
module pdn_fsm
    import pdn_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pd_req,
    input  logic exit_req,
    input  logic blocked,
    input  logic expire,
    input  logic banks_idle,
    output logic cke,
    output logic cmd_nop,
    output logic cmd_ready,
    output logic pd_mode,
    output logic in_down
);
    pdn_state_e state_q, state_d;
    pdn_mode_e  mode_q;
    logic       pend_q;
    logic       want_pd, go;

    assign want_pd = pend_q | pd_req;
    assign go      = (state_q == S_UP) && want_pd && !blocked;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_UP:    if (go) state_d = S_ENTER;
            S_ENTER: state_d = S_DOWN;
            S_DOWN:  if (exit_req || expire) state_d = S_EXIT;
            S_EXIT:  state_d = S_UP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_UP;
            pend_q  <= 1'b0;
            mode_q  <= MODE_PRECHARGE;
        end else begin
            state_q <= state_d;
            pend_q  <= (state_q == S_UP) && want_pd && blocked;
            if (go) mode_q <= banks_idle ? MODE_PRECHARGE : MODE_ACTIVE;
        end
    end

    always_comb begin
        cke       = 1'b1;
        cmd_nop   = 1'b0;
        cmd_ready = 1'b0;
        in_down   = 1'b0;
        unique case (state_q)
            S_UP:    cmd_ready = 1'b1;
            S_ENTER: begin cke = 1'b0; cmd_nop = 1'b1; end
            S_DOWN:  begin cke = 1'b0; in_down = 1'b1; end
            S_EXIT:  cmd_nop = 1'b1;
        endcase
    end

    assign pd_mode = mode_q;

    p_no_entry_in_burst_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_UP && blocked) |=> cke);
    p_fall_with_nop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> cmd_nop);
    p_rise_with_nop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> (cmd_nop && !cmd_ready));
    p_ready_after_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_EXIT) |=> cmd_ready);
    p_ready_needs_cke_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> !cmd_ready);
    p_mode_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DOWN || state_q == S_EXIT) |-> $stable(pd_mode));
    p_exit_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ENTER && exit_req) |=> !cke);
endmodule

// File: rtl/ddr_pdn_ctrl.sv
module ddr_pdn_ctrl #(
    parameter int MAX_PD_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_req,
    input  logic exit_req,
    input  logic burst_busy,
    input  logic postamble_done,
    input  logic banks_idle,
    output logic cke,
    output logic cmd_nop,
    output logic cmd_ready,
    output logic pd_mode
);
    logic blocked, expire, in_down;

    pdn_burst_guard u_guard (
        .clk            (clk),
        .rst_n          (rst_n),
        .burst_busy     (burst_busy),
        .postamble_done (postamble_done),
        .blocked        (blocked)
    );

    pdn_dwell_timer #(.MAX_PD_CYCLES(MAX_PD_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_down (in_down),
        .expire  (expire)
    );

    pdn_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pd_req     (pd_req),
        .exit_req   (exit_req),
        .blocked    (blocked),
        .expire     (expire),
        .banks_idle (banks_idle),
        .cke        (cke),
        .cmd_nop    (cmd_nop),
        .cmd_ready  (cmd_ready),
        .pd_mode    (pd_mode),
        .in_down    (in_down)
    );
endmodule

// File: tb/test_ddr_pdn_ctrl.sv
module test_ddr_pdn_ctrl;
    localparam int MAXC = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pd_req = 1'b0, exit_req = 1'b0, burst_busy = 1'b0;
    logic postamble_done = 1'b0, banks_idle = 1'b1;
    logic cke, cmd_nop, cmd_ready, pd_mode;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic  cke;
        logic  nop;
        logic  rdy;
        logic  mode;
        string tag;
    } exp_t;

    exp_t q[$];

    always #2 clk = ~clk;

    ddr_pdn_ctrl #(.MAX_PD_CYCLES(MAXC)) i_ddr_pdn_ctrl (
        .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .exit_req(exit_req),
        .burst_busy(burst_busy), .postamble_done(postamble_done),
        .banks_idle(banks_idle), .cke(cke), .cmd_nop(cmd_nop),
        .cmd_ready(cmd_ready), .pd_mode(pd_mode)
    );

    task automatic compare(input exp_t e);
        checks++;
        if ({cke, cmd_nop, cmd_ready, pd_mode} !== {e.cke, e.nop, e.rdy, e.mode}) begin
            errors++;
            $display("FAIL %s: cke/nop/ready/mode got %b%b%b%b expected %b%b%b%b",
                     e.tag, cke, cmd_nop, cmd_ready, pd_mode, e.cke, e.nop, e.rdy, e.mode);
        end
    endtask

    // Monitor: the outputs after each edge are compared with the oldest expectation.
    initial forever begin
        @(posedge clk);
        #1;
        if (q.size() > 0) compare(q.pop_front());
    end

    // Driver: apply one cycle of inputs and queue the state expected after the edge.
    task automatic cyc(input logic pd, input logic ex, input logic bb, input logic pa,
                       input logic idle, input logic ec, input logic en, input logic er,
                       input logic em, input string tag);
        exp_t e;
        @(negedge clk);
        pd_req = pd; exit_req = ex; burst_busy = bb;
        postamble_done = pa; banks_idle = idle;
        e.cke = ec; e.nop = en; e.rdy = er; e.mode = em; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #80000;
        errors++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        finish_run();
    end

    initial begin
        exp_t r;
        repeat (3) @(negedge clk);
        r.cke = 1; r.nop = 0; r.rdy = 1; r.mode = 0; r.tag = "R1 reset state";
        compare(r);
        rst_n = 1'b1;

        cyc(0,0,0,0,1, 1,0,1,0, "R1 idle after reset");
        cyc(0,1,0,0,1, 1,0,1,0, "R8 exit request while up ignored");

        // Precharge power-down with an explicit exit.
        cyc(1,0,0,0,1, 0,1,0,0, "R2 entry cycle precharge");
        cyc(0,0,0,0,1, 0,0,0,0, "R5 dwell");
        cyc(1,0,0,0,1, 0,0,0,0, "R5 request during dwell");
        cyc(0,1,0,0,1, 1,1,0,0, "R6 R9 exit cycle with nop");
        cyc(0,0,0,0,1, 1,0,1,0, "R6 ready after exit");
        cyc(0,0,0,0,1, 1,0,1,0, "R5 discarded request causes no entry");

        // Active power-down: mode is captured at entry and then held.
        cyc(1,0,0,0,0, 0,1,0,1, "R4 active entry");
        cyc(0,0,0,0,1, 0,0,0,1, "R4 mode held in dwell");
        cyc(0,1,0,0,1, 1,1,0,1, "R6 exit from active");
        cyc(0,0,0,0,1, 1,0,1,1, "R4 mode kept after exit");

        // A request during a burst waits for the postamble.
        cyc(1,0,1,0,1, 1,0,1,1, "R3 request during burst held");
        cyc(0,0,1,0,1, 1,0,1,1, "R3 burst still busy");
        cyc(0,0,0,0,1, 1,0,1,1, "R3 waiting for postamble");
        cyc(0,0,0,1,1, 1,0,1,1, "R3 postamble cycle");
        cyc(0,0,0,0,1, 0,1,0,0, "R3 held request honoured");
        cyc(0,1,0,0,1, 0,0,0,0, "R8 exit during entry ignored");
        cyc(0,1,0,0,1, 1,1,0,0, "R6 exit");
        cyc(0,0,0,0,1, 1,0,1,0, "R6 ready");

        // Forced exit when the dwell limit runs out.
        cyc(1,0,0,0,1, 0,1,0,0, "R7 entry");
        for (int i = 0; i < MAXC; i++)
            cyc(0,0,0,0,1, 0,0,0,0, "R7 dwell below limit");
        cyc(0,0,0,0,1, 1,1,0,0, "R7 forced exit");
        cyc(0,0,0,0,1, 1,0,1,0, "R7 ready after forced exit");

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule